// File: doc/BRIEF.md
# Interrupt Entry State Sequencer

This block steps a processor core into an interrupt service routine once the interrupt controller offers a request whose priority beats the current one. It first asks a context-save unit to store the upper context. While that save runs, the block presents the previous priority and previous enable values that belong in the saved-context link register. Nothing else in the core changes until the save unit reports that it is done.

After a clean save, the block writes every architectural update in one commit cycle. The global enable is cleared and the current priority takes the priority of the request. The status word is forced to its entry defaults, and the stack pointer is switched to the interrupt stack if the core was running on the user stack. In the same cycle the block pulses a fetch request that carries the vector address and acknowledges the interrupt controller. If the save unit reports a fault instead, the block leaves the core untouched and raises a trap-redirect pulse. The request stays pending and is taken again later.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only when `irq_valid` is 1, `cur_ie` is 1 and `irq_prio` is strictly greater than `cur_ccpn` (unsigned). Otherwise `save_req` stays 0.
- R2: On the clock edge that accepts a request, `save_req` becomes 1 and stays 1 until `save_done` or `save_fault` is seen. During that time `save_pcpn` and `save_pie` show the `cur_ccpn` and `cur_ie` values from the accepting edge.
- R3: When `save_done` is 1 and `save_fault` is 0 while `save_req` is 1, `commit` is 1 for exactly one cycle, starting on the next edge. In that cycle `new_ie` is 0, `new_ccpn` holds the accepted priority, and `save_req` is 0.
- R4: While `commit` is 1, the status defaults are `new_io` = 2'b10, `new_prs` = 2'b00, `new_is` = 1 and `new_cdc` = 7'b0.
- R5: The stack-pointer switch depends on `cur_is` sampled at acceptance. If it was 0, the commit cycle has `sp_we` = 1 and `new_sp` = `isp`. If it was 1, `sp_we` = 0 and `new_sp` equals `cur_sp`.
- R6: `fetch_req` is 1 only in the commit cycle. At that time `fetch_addr` = `biv` OR (accepted priority shifted left by 5).
- R7: If `save_fault` is 1 while `save_req` is 1, then on the next edge `trap_redirect` pulses for one cycle and `save_req` drops. No `commit`, `irq_ack` or `fetch_req` follows. A request that is still pending is accepted again afterwards.
- R8: A fault takes precedence when `save_fault` and `save_done` arrive in the same cycle.
- R9: `irq_ack` is 1 only in a commit cycle, never after an aborted entry.
- R10: A synchronous active-high `rst` returns the block to idle with `save_req`, `commit`, `fetch_req`, `irq_ack` and `trap_redirect` at 0.
- R11: Once a request is accepted, changes to `irq_prio` and `cur_ccpn` have no effect on the entry in progress. The captured priority is what reaches `new_ccpn` and `fetch_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_valid | input | 1 | Interrupt request pending |
| irq_prio | input | 8 | Priority of the pending request |
| cur_ie | input | 1 | Current global interrupt enable |
| cur_ccpn | input | 8 | Current CPU priority number |
| cur_is | input | 1 | Current interrupt-stack flag |
| cur_sp | input | 32 | Current stack pointer |
| isp | input | 32 | Interrupt stack pointer |
| biv | input | 32 | Vector table base |
| save_req | output | 1 | Upper-context save request |
| save_pcpn | output | 8 | Previous priority for the link register |
| save_pie | output | 1 | Previous enable for the link register |
| save_done | input | 1 | Save completed |
| save_fault | input | 1 | Save aborted by a fault |
| commit | output | 1 | Register update strobe |
| new_ie | output | 1 | New global enable |
| new_ccpn | output | 8 | New current priority |
| new_io | output | 2 | New I/O privilege field |
| new_prs | output | 2 | New protection set select |
| new_is | output | 1 | New interrupt-stack flag |
| new_cdc | output | 7 | New call depth counter field |
| sp_we | output | 1 | Stack pointer write enable |
| new_sp | output | 32 | New stack pointer value |
| fetch_req | output | 1 | First-instruction fetch pulse |
| fetch_addr | output | 32 | Vector fetch address |
| irq_ack | output | 1 | Acknowledge to interrupt controller |
| trap_redirect | output | 1 | Entry aborted, divert to trap |

## Verification
The hardest situation to reach is a fault that aborts an entry while the request is still present. The block must fall back to idle without touching any state and then accept the same request again. The bench holds `irq_valid` high across a faulted save and watches the trap pulse. It then checks that a fresh save request appears on the following edge and that this second attempt completes. A separate task raises fault and done in the same cycle to confirm that the fault wins. Another task changes the priority inputs in the middle of a save to show that the captured priority is the one used.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAVE   = 2'd1,
    ST_COMMIT = 2'd2
  } entry_state_e;

  localparam logic [1:0] IO_FULL_ACCESS = 2'b10;
  localparam logic [1:0] PRS_ENTRY      = 2'b00;
  localparam logic       IS_ON_ENTRY    = 1'b1;
  localparam int         CDC_W          = 7;
endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
  parameter int PW = 8
) (
  input  logic          irq_valid,
  input  logic [PW-1:0] irq_prio,
  input  logic          cur_ie,
  input  logic [PW-1:0] cur_ccpn,
  output logic          accept
);
  always_comb begin
    accept = irq_valid && cur_ie && (irq_prio > cur_ccpn);
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
  parameter int AW        = 32,
  parameter int PW        = 8,
  parameter int VEC_SHIFT = 5
) (
  input  logic [AW-1:0] biv,
  input  logic [PW-1:0] prio,
  output logic [AW-1:0] vec_addr
);
  localparam int PAD = AW - PW;
  logic [AW-1:0] prio_wide;

  always_comb begin
    prio_wide = {{PAD{1'b0}}, prio};
    vec_addr  = biv | (prio_wide << VEC_SHIFT);
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic [PW-1:0] irq_prio,
  input  logic          cur_ie,
  input  logic [PW-1:0] cur_ccpn,
  input  logic          cur_is,
  input  logic [AW-1:0] cur_sp,
  input  logic [AW-1:0] isp,
  input  logic [AW-1:0] vec_addr,
  input  logic          save_done,
  input  logic          save_fault,
  output logic [PW-1:0] prio_q,
  output logic          save_req,
  output logic [PW-1:0] save_pcpn,
  output logic          save_pie,
  output logic          commit,
  output logic [PW-1:0] new_ccpn,
  output logic          sp_we,
  output logic [AW-1:0] new_sp,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic          irq_ack,
  output logic          trap_redirect
);
  entry_state_e state;
  logic         was_int_stack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      save_req      <= 1'b0;
      save_pcpn     <= '0;
      save_pie      <= 1'b0;
      prio_q        <= '0;
      was_int_stack <= 1'b0;
      commit        <= 1'b0;
      new_ccpn      <= '0;
      sp_we         <= 1'b0;
      new_sp        <= '0;
      fetch_req     <= 1'b0;
      fetch_addr    <= '0;
      irq_ack       <= 1'b0;
      trap_redirect <= 1'b0;
    end else begin
      commit        <= 1'b0;
      fetch_req     <= 1'b0;
      irq_ack       <= 1'b0;
      sp_we         <= 1'b0;
      trap_redirect <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state         <= ST_SAVE;
            save_req      <= 1'b1;
            prio_q        <= irq_prio;
            save_pcpn     <= cur_ccpn;
            save_pie      <= cur_ie;
            was_int_stack <= cur_is;
          end
        end
        ST_SAVE: begin
          if (save_fault) begin
            state         <= ST_IDLE;
            save_req      <= 1'b0;
            trap_redirect <= 1'b1;
          end else if (save_done) begin
            state      <= ST_COMMIT;
            save_req   <= 1'b0;
            commit     <= 1'b1;
            irq_ack    <= 1'b1;
            fetch_req  <= 1'b1;
            fetch_addr <= vec_addr;
            new_ccpn   <= prio_q;
            sp_we      <= !was_int_stack;
            new_sp     <= was_int_stack ? cur_sp : isp;
          end
        end
        ST_COMMIT: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R2
  save_held_chk: assert property (@(posedge clk) disable iff (rst)
    save_req && !save_done && !save_fault |=> save_req && $stable(save_pcpn) && $stable(save_pie));

  // R3
  done_commit_chk: assert property (@(posedge clk) disable iff (rst)
    save_req && save_done && !save_fault |=> commit && !save_req);

  // R3
  commit_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R7
  fault_trap_chk: assert property (@(posedge clk) disable iff (rst)
    save_req && save_fault |=> trap_redirect && !commit && !fetch_req && !irq_ack);

  // R5
  sp_we_in_commit_chk: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> commit);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PW        = 8,
  parameter int VEC_SHIFT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_valid,
  input  logic [PW-1:0] irq_prio,
  input  logic          cur_ie,
  input  logic [PW-1:0] cur_ccpn,
  input  logic          cur_is,
  input  logic [AW-1:0] cur_sp,
  input  logic [AW-1:0] isp,
  input  logic [AW-1:0] biv,
  output logic          save_req,
  output logic [PW-1:0] save_pcpn,
  output logic          save_pie,
  input  logic          save_done,
  input  logic          save_fault,
  output logic          commit,
  output logic          new_ie,
  output logic [PW-1:0] new_ccpn,
  output logic [1:0]    new_io,
  output logic [1:0]    new_prs,
  output logic          new_is,
  output logic [CDC_W-1:0] new_cdc,
  output logic          sp_we,
  output logic [AW-1:0] new_sp,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  output logic          irq_ack,
  output logic          trap_redirect
);
  logic          accept;
  logic [PW-1:0] prio_q;
  logic [AW-1:0] vec_addr;

  irq_accept_gate #(.PW(PW)) u_gate (
    .irq_valid (irq_valid),
    .irq_prio  (irq_prio),
    .cur_ie    (cur_ie),
    .cur_ccpn  (cur_ccpn),
    .accept    (accept)
  );

  irq_vector_gen #(.AW(AW), .PW(PW), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .biv      (biv),
    .prio     (prio_q),
    .vec_addr (vec_addr)
  );

  irq_entry_fsm #(.AW(AW), .PW(PW)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .accept        (accept),
    .irq_prio      (irq_prio),
    .cur_ie        (cur_ie),
    .cur_ccpn      (cur_ccpn),
    .cur_is        (cur_is),
    .cur_sp        (cur_sp),
    .isp           (isp),
    .vec_addr      (vec_addr),
    .save_done     (save_done),
    .save_fault    (save_fault),
    .prio_q        (prio_q),
    .save_req      (save_req),
    .save_pcpn     (save_pcpn),
    .save_pie      (save_pie),
    .commit        (commit),
    .new_ccpn      (new_ccpn),
    .sp_we         (sp_we),
    .new_sp        (new_sp),
    .fetch_req     (fetch_req),
    .fetch_addr    (fetch_addr),
    .irq_ack       (irq_ack),
    .trap_redirect (trap_redirect)
  );

  // Entry defaults are fixed values; they are qualified by commit.
  assign new_ie  = 1'b0;
  assign new_io  = IO_FULL_ACCESS;
  assign new_prs = PRS_ENTRY;
  assign new_is  = IS_ON_ENTRY;
  assign new_cdc = '0;

  // R1
  accept_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(save_req) |-> $past(irq_valid && cur_ie && (irq_prio > cur_ccpn)));

  // R9
  ack_only_commit_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> commit && fetch_req);

  // R6
  fetch_only_commit_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> commit);

  // R8
  fault_wins_chk: assert property (@(posedge clk) disable iff (rst)
    save_req && save_fault && save_done |=> !commit && trap_redirect);
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        irq_valid;
  logic [7:0]  irq_prio;
  logic        cur_ie;
  logic [7:0]  cur_ccpn;
  logic        cur_is;
  logic [31:0] cur_sp, isp, biv;
  logic        save_req, save_pie, save_done, save_fault;
  logic [7:0]  save_pcpn, new_ccpn;
  logic        commit, new_ie, new_is, sp_we, fetch_req, irq_ack, trap_redirect;
  logic [1:0]  new_io, new_prs;
  logic [6:0]  new_cdc;
  logic [31:0] new_sp, fetch_addr;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_prio(irq_prio),
    .cur_ie(cur_ie), .cur_ccpn(cur_ccpn), .cur_is(cur_is), .cur_sp(cur_sp),
    .isp(isp), .biv(biv), .save_req(save_req), .save_pcpn(save_pcpn),
    .save_pie(save_pie), .save_done(save_done), .save_fault(save_fault),
    .commit(commit), .new_ie(new_ie), .new_ccpn(new_ccpn), .new_io(new_io),
    .new_prs(new_prs), .new_is(new_is), .new_cdc(new_cdc), .sp_we(sp_we),
    .new_sp(new_sp), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .irq_ack(irq_ack), .trap_redirect(trap_redirect)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    irq_valid = 0; save_done = 0; save_fault = 0;
    step(); step();
  endtask

  task automatic t_reset();
    rst = 1; irq_valid = 1; irq_prio = 8'h40; cur_ie = 1; cur_ccpn = 0;
    cur_is = 0; cur_sp = 0; isp = 0; biv = 0; save_done = 0; save_fault = 0;
    step(); step(); step();
    eq("R10 save_req", save_req, 0);
    eq("R10 commit", commit, 0);
    eq("R10 fetch_req", fetch_req, 0);
    eq("R10 irq_ack", irq_ack, 0);
    eq("R10 trap", trap_redirect, 0);
    irq_valid = 0;
    step();
    rst = 0;
    step();
  endtask

  task automatic t_reject();
    irq_valid = 1; cur_ie = 0; irq_prio = 8'h09; cur_ccpn = 8'h02;
    step(); step();
    eq("R1 disabled", save_req, 0);
    cur_ie = 1; irq_prio = 8'h02;
    step(); step();
    eq("R1 equal prio", save_req, 0);
    irq_prio = 8'h01;
    step(); step();
    eq("R1 lower prio", save_req, 0);
    irq_valid = 0; irq_prio = 8'h09;
    step(); step();
    eq("R1 not valid", save_req, 0);
  endtask

  task automatic t_user_stack();
    cur_ie = 1; cur_ccpn = 8'h03; cur_is = 0; cur_sp = 32'h0000_1000;
    isp = 32'h2000_0100; biv = 32'h8000_0000; irq_prio = 8'h21; irq_valid = 1;
    step();
    eq("R2 save_req", save_req, 1);
    eq("R2 pcpn", save_pcpn, 8'h03);
    eq("R2 pie", save_pie, 1);
    eq("R3 no early commit", commit, 0);
    step();
    eq("R2 held", save_req, 1);
    save_done = 1;
    step();
    save_done = 0; irq_valid = 0; cur_ie = 0;
    eq("R3 commit", commit, 1);
    eq("R3 new_ie", new_ie, 0);
    eq("R3 new_ccpn", new_ccpn, 8'h21);
    eq("R3 save_req low", save_req, 0);
    eq("R4 io", new_io, 2'b10);
    eq("R4 prs", new_prs, 2'b00);
    eq("R4 is", new_is, 1);
    eq("R4 cdc", new_cdc, 0);
    eq("R5 sp_we", sp_we, 1);
    eq("R5 new_sp", new_sp, 32'h2000_0100);
    eq("R6 fetch_req", fetch_req, 1);
    eq("R6 fetch_addr", fetch_addr, 32'h8000_0420);
    eq("R9 ack", irq_ack, 1);
    step();
    eq("R3 one cycle", commit, 0);
    eq("R6 fetch pulse", fetch_req, 0);
    eq("R9 ack pulse", irq_ack, 0);
    quiet();
  endtask

  task automatic t_int_stack();
    cur_ie = 1; cur_ccpn = 8'h10; cur_is = 1; cur_sp = 32'hDEAD_0000;
    isp = 32'h2000_0100; biv = 32'h0001_0000; irq_prio = 8'hFF; irq_valid = 1;
    step();
    save_done = 1;
    step();
    save_done = 0; irq_valid = 0; cur_ie = 0;
    eq("R5 int stack sp_we", sp_we, 0);
    eq("R5 int stack sp", new_sp, 32'hDEAD_0000);
    eq("R6 top prio addr", fetch_addr, 32'h0001_1FE0);
    quiet();
  endtask

  task automatic t_fault();
    cur_ie = 1; cur_ccpn = 0; cur_is = 0; irq_prio = 8'h05; irq_valid = 1;
    biv = 32'h0000_4000;
    step();
    eq("R7 save started", save_req, 1);
    save_fault = 1;
    step();
    save_fault = 0;
    eq("R7 trap", trap_redirect, 1);
    eq("R7 no commit", commit, 0);
    eq("R7 no fetch", fetch_req, 0);
    eq("R9 no ack on fault", irq_ack, 0);
    eq("R7 save dropped", save_req, 0);
    step();
    eq("R7 trap pulse", trap_redirect, 0);
    eq("R7 retaken", save_req, 1);
    save_done = 1;
    step();
    save_done = 0; irq_valid = 0; cur_ie = 0;
    eq("R7 retry commit", commit, 1);
    eq("R7 retry addr", fetch_addr, 32'h0000_40A0);
    quiet();
  endtask

  task automatic t_fault_and_done();
    cur_ie = 1; cur_ccpn = 0; irq_prio = 8'h07; irq_valid = 1;
    step();
    save_fault = 1; save_done = 1;
    step();
    save_fault = 0; save_done = 0; irq_valid = 0;
    eq("R8 trap", trap_redirect, 1);
    eq("R8 no commit", commit, 0);
    eq("R8 no ack", irq_ack, 0);
    step();
    eq("R8 stays idle", commit, 0);
    quiet();
  endtask

  task automatic t_busy();
    cur_ie = 1; cur_ccpn = 0; cur_is = 1; irq_prio = 8'h10; irq_valid = 1;
    biv = 32'h0000_0000;
    step();
    irq_prio = 8'h40; cur_ccpn = 8'h07;
    step();
    eq("R11 pcpn kept", save_pcpn, 0);
    save_done = 1;
    step();
    save_done = 0; irq_valid = 0; cur_ie = 0;
    eq("R11 ccpn kept", new_ccpn, 8'h10);
    eq("R11 addr kept", fetch_addr, 32'h0000_0200);
    quiet();
  endtask

  initial begin
    t_reset();
    t_reject();
    t_user_stack();
    t_int_stack();
    t_fault();
    t_fault_and_done();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule